// File: doc/BRIEF.md
# Early Tag Lookup Mirror

This block keeps a shadow copy of an L1 data cache's tag store and of its small address-translation table, so that the destination way of a memory instruction can be found while the instruction sits in the load/store queue, before the real cache access. It is a lookup-only mirror. Every tag write and every translation write made to the main L1 structures is also presented on this block's update ports, with the same set, way or slot and the same value, so both copies stay identical to the originals.

A lookup presents the untranslated set index and the virtual page number. The translation copy is a fully associative table, and it is searched in the same cycle as the tag copy. The physical page it returns is compared against the tags of every way in the addressed set. The cache is virtually indexed and physically tagged. One clock later the block reports one of three outcomes:

- an early hit, with the way number and the physical page;
- an early tag miss, with the physical page;
- an early translation miss.

When an update writes an entry in the same cycle that a lookup reads it, that entry is treated as not matching for that lookup, which avoids a read/write conflict.

Top module: `eta_lookup_top`

## Requirements
- R1: After reset no result is flagged, and every tag entry and every translation entry is invalid, so the first lookup reports a translation miss.
- R2: The result of a lookup appears on the clock edge after `lk_valid` is high. `rs_valid` is `lk_valid` delayed by one clock. While `rs_valid` is low, `rs_hit`, `rs_tag_miss`, `rs_xlt_miss`, `rs_way` and `rs_ppn` are all zero.
- R3: When a valid translation slot holds the looked-up virtual page, `rs_ppn` gives that slot's physical page. If several slots match, the lowest-numbered slot wins.
- R4: When no valid translation slot matches, `rs_xlt_miss` is 1 and `rs_tag_miss`, `rs_hit`, `rs_way` and `rs_ppn` are 0. This holds even if the tags would also miss.
- R5: When the translation hits and a valid way in set `lk_set` holds a tag equal to the translated page, `rs_hit` is 1 and `rs_way` is that way's number. If several ways match, the lowest-numbered way wins.
- R6: When the translation hits but no way of the set matches, `rs_tag_miss` is 1, `rs_way` is 0 and `rs_ppn` still carries the translated page.
- R7: Whenever `rs_valid` is 1, exactly one of `rs_hit`, `rs_tag_miss` and `rs_xlt_miss` is 1.
- R8: A tag write (`tg_wr_en`) stores `tg_wr_valid` and `tg_wr_tag` at (`tg_wr_set`, `tg_wr_way`), and a translation write (`xl_wr_en`) stores valid, virtual page and physical page at slot `xl_wr_slot`. A write with valid 0 invalidates the entry. Lookups from the next cycle onward see the new contents.
- R9: If a tag write targets the looked-up set in the same cycle as a lookup, the written way counts as not matching for that lookup, whatever its old or new contents. The other ways of the set are unaffected.
- R10: If a translation write targets a slot in the same cycle as a lookup, that slot counts as not matching for that lookup. The other slots are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_set | input | IDX_W | Set index from untranslated address bits |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| tg_wr_en | input | 1 | Mirror of a main tag-array write |
| tg_wr_set | input | IDX_W | Set being written |
| tg_wr_way | input | WAY_W | Way being written |
| tg_wr_valid | input | 1 | Valid bit written with the tag |
| tg_wr_tag | input | PPN_W | Physical tag written |
| xl_wr_en | input | 1 | Mirror of a main translation-table write |
| xl_wr_slot | input | SLOT_W | Translation slot being written |
| xl_wr_valid | input | 1 | Valid bit written with the slot |
| xl_wr_vpn | input | VPN_W | Virtual page stored in the slot |
| xl_wr_ppn | input | PPN_W | Physical page stored in the slot |
| rs_valid | output | 1 | A lookup result is present |
| rs_hit | output | 1 | Early hit |
| rs_way | output | WAY_W | Early destination way, valid with `rs_hit` |
| rs_ppn | output | PPN_W | Translated physical page |
| rs_tag_miss | output | 1 | Translation hit, tag miss |
| rs_xlt_miss | output | 1 | Translation miss |

## Verification
A stale or lost entry in either copy shows up at the ports on the very next lookup that touches it. The symptom is a wrong outcome flag, a wrong way or a wrong page one clock after the address, and it appears against a reference model that receives the same update stream. Conflict blocking is hit on purpose by writing to the set or slot being looked up in the same cycle. A missing block shows up as a hit that the model turns into a miss, again one clock later. Because updates are dense and both the page and tag ranges are small, duplicate matches also occur, and these exercise the lowest-index priority of both searches.

// File: rtl/eta_pkg.sv
package eta_pkg;

  typedef enum logic [1:0] {
    RES_NONE     = 2'd0,
    RES_HIT      = 2'd1,
    RES_TAG_MISS = 2'd2,
    RES_XLT_MISS = 2'd3
  } res_kind_e;

  // lowest set bit position of a match vector (0 when empty)
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // translation miss dominates a tag miss
  function automatic res_kind_e classify(input logic valid, input logic xlt_hit,
                                         input logic tag_hit);
    if (!valid)        return RES_NONE;
    else if (!xlt_hit) return RES_XLT_MISS;
    else if (!tag_hit) return RES_TAG_MISS;
    else               return RES_HIT;
  endfunction

endpackage

// File: rtl/eta_xlt_copy.sv
module eta_xlt_copy #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 8,
  parameter int PPN_W   = 8,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  rd_vpn,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  output logic              hit,
  output logic [PPN_W-1:0]  ppn
);
  import eta_pkg::*;

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] slot_block;
  logic [ENTRIES-1:0] slot_match;
  logic [PPN_W-1:0]   ppn_arr [ENTRIES];

  for (genvar s = 0; s < ENTRIES; s++) begin : g_slot
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             sel;

    assign sel           = wr_en && (wr_slot == SLOT_W'(s));
    assign slot_block[s] = sel;
    assign slot_match[s] = vld_q[s] && (vpn_q == rd_vpn) && !slot_block[s];
    assign ppn_arr[s]    = ppn_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q[s] <= 1'b0;
      else if (sel) vld_q[s] <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_q <= wr_vpn;
        ppn_q <= wr_ppn;
      end
    end

    // R8: an invalidating write clears the slot
    p_slot_inval_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_slot == SLOT_W'(s) && !wr_valid) |=> !vld_q[s]);
  end

  logic [SLOT_W-1:0] pick;
  assign pick = SLOT_W'(lowest_set(32'(slot_match)));
  assign hit  = |slot_match;
  assign ppn  = hit ? ppn_arr[pick] : '0;

  // R10: a blocked slot never contributes to the search
  p_slot_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit) |-> (pick != wr_slot));

endmodule

// File: rtl/eta_tag_copy.sv
module eta_tag_copy #(
  parameter int NUM_WAYS = 2,
  parameter int IDX_W    = 2,
  parameter int PPN_W    = 8,
  localparam int SETS    = 1 << IDX_W,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_set,
  input  logic [PPN_W-1:0]    rd_tag,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_set,
  input  logic [WAY_W-1:0]    wr_way,
  input  logic                wr_valid,
  input  logic [PPN_W-1:0]    wr_tag,
  output logic [NUM_WAYS-1:0] way_match,
  output logic [NUM_WAYS-1:0] way_block
);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [PPN_W-1:0] tag_q [SETS];
    logic             way_sel;

    // per-way replacement enable, then the write decoder's set select
    assign way_sel      = wr_en && (wr_way == WAY_W'(w));
    assign way_block[w] = way_sel && (wr_set == rd_set);
    assign way_match[w] = vld_q[rd_set] && (tag_q[rd_set] == rd_tag) && !way_block[w];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld_q <= '0;
      else if (way_sel) vld_q[wr_set] <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (way_sel) tag_q[wr_set] <= wr_tag;
    end

    // R8: an invalidating write clears the entry
    p_way_inval_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_way == WAY_W'(w) && !wr_valid) |=> !vld_q[$past(wr_set)]);

    // R8: a validating write sets the entry
    p_way_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_way == WAY_W'(w) && wr_valid) |=> vld_q[$past(wr_set)]);
  end

endmodule

// File: rtl/eta_lookup_top.sv
module eta_lookup_top #(
  parameter int NUM_WAYS    = 2,
  parameter int IDX_W       = 2,
  parameter int XLT_ENTRIES = 4,
  parameter int VPN_W       = 8,
  parameter int PPN_W       = 8,
  localparam int WAY_W      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SLOT_W     = (XLT_ENTRIES > 1) ? $clog2(XLT_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [IDX_W-1:0]  lk_set,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              tg_wr_en,
  input  logic [IDX_W-1:0]  tg_wr_set,
  input  logic [WAY_W-1:0]  tg_wr_way,
  input  logic              tg_wr_valid,
  input  logic [PPN_W-1:0]  tg_wr_tag,
  input  logic              xl_wr_en,
  input  logic [SLOT_W-1:0] xl_wr_slot,
  input  logic              xl_wr_valid,
  input  logic [VPN_W-1:0]  xl_wr_vpn,
  input  logic [PPN_W-1:0]  xl_wr_ppn,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic [WAY_W-1:0]  rs_way,
  output logic [PPN_W-1:0]  rs_ppn,
  output logic              rs_tag_miss,
  output logic              rs_xlt_miss
);
  import eta_pkg::*;

  // internal events brought out for the checks
  logic                xlt_hit;
  logic [PPN_W-1:0]    xlt_ppn;
  logic [NUM_WAYS-1:0] way_match;
  logic [NUM_WAYS-1:0] way_block;
  logic                tag_hit;
  logic [WAY_W-1:0]    hit_way;
  res_kind_e           kind_d;

  eta_xlt_copy #(
    .ENTRIES (XLT_ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_xlt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_vpn   (lk_vpn),
    .wr_en    (xl_wr_en),
    .wr_slot  (xl_wr_slot),
    .wr_valid (xl_wr_valid),
    .wr_vpn   (xl_wr_vpn),
    .wr_ppn   (xl_wr_ppn),
    .hit      (xlt_hit),
    .ppn      (xlt_ppn)
  );

  eta_tag_copy #(
    .NUM_WAYS (NUM_WAYS),
    .IDX_W    (IDX_W),
    .PPN_W    (PPN_W)
  ) u_tag (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_set    (lk_set),
    .rd_tag    (xlt_ppn),
    .wr_en     (tg_wr_en),
    .wr_set    (tg_wr_set),
    .wr_way    (tg_wr_way),
    .wr_valid  (tg_wr_valid),
    .wr_tag    (tg_wr_tag),
    .way_match (way_match),
    .way_block (way_block)
  );

  assign tag_hit = xlt_hit && (|way_match);
  assign hit_way = WAY_W'(lowest_set(32'(way_match)));
  assign kind_d  = classify(lk_valid, xlt_hit, tag_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid    <= 1'b0;
      rs_hit      <= 1'b0;
      rs_tag_miss <= 1'b0;
      rs_xlt_miss <= 1'b0;
      rs_way      <= '0;
      rs_ppn      <= '0;
    end else begin
      rs_valid    <= lk_valid;
      rs_hit      <= (kind_d == RES_HIT);
      rs_tag_miss <= (kind_d == RES_TAG_MISS);
      rs_xlt_miss <= (kind_d == RES_XLT_MISS);
      rs_way      <= (kind_d == RES_HIT) ? hit_way : '0;
      rs_ppn      <= (kind_d == RES_HIT || kind_d == RES_TAG_MISS) ? xlt_ppn : '0;
    end
  end

  // R2: result follows the lookup by one clock
  p_result_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rs_valid);
  p_no_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> (!rs_hit && !rs_tag_miss && !rs_xlt_miss && rs_way == '0 && rs_ppn == '0));

  // R7: exactly one outcome per result
  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> ($countones({rs_hit, rs_tag_miss, rs_xlt_miss}) == 1));

  // R4: translation miss carries no page or way
  p_xlt_miss_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rs_xlt_miss |-> (rs_ppn == '0 && rs_way == '0));

  // R9: a way written in the lookup cycle is never reported as the hit way
  p_conflict_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && tg_wr_en && tg_wr_set == lk_set)
      |=> !(rs_hit && rs_way == $past(tg_wr_way)));

  // R9: blocking and matching of a way are exclusive
  p_block_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (way_block & way_match) == '0);

endmodule

// File: tb/tb_eta_lookup_top.sv
module tb_eta_lookup_top;

  localparam int NW = 2, IW = 2, XE = 4, VW = 8, PW = 8;
  localparam int SETS = 1 << IW;
  localparam int WW = 1, SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          lk_valid = 0;
  logic [IW-1:0] lk_set = 0;
  logic [VW-1:0] lk_vpn = 0;
  logic          tg_wr_en = 0;
  logic [IW-1:0] tg_wr_set = 0;
  logic [WW-1:0] tg_wr_way = 0;
  logic          tg_wr_valid = 0;
  logic [PW-1:0] tg_wr_tag = 0;
  logic          xl_wr_en = 0;
  logic [SW-1:0] xl_wr_slot = 0;
  logic          xl_wr_valid = 0;
  logic [VW-1:0] xl_wr_vpn = 0;
  logic [PW-1:0] xl_wr_ppn = 0;
  logic          rs_valid, rs_hit, rs_tag_miss, rs_xlt_miss;
  logic [WW-1:0] rs_way;
  logic [PW-1:0] rs_ppn;

  eta_lookup_top dut (.*);

  // reference copy of the main structures
  logic          m_tv [SETS][NW];
  logic [PW-1:0] m_tt [SETS][NW];
  logic          m_xv [XE];
  logic [VW-1:0] m_xvpn [XE];
  logic [PW-1:0] m_xppn [XE];

  logic          e_valid, e_hit, e_tm, e_xm;
  logic [WW-1:0] e_way;
  logic [PW-1:0] e_ppn;
  bit            pend = 0;
  int            total = 0, bad = 0;
  bit            done = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic check_result();
    chk("R2", "rs_valid", 32'(rs_valid), 32'(e_valid));
    chk("R5", "rs_hit", 32'(rs_hit), 32'(e_hit));
    chk("R5", "rs_way", 32'(rs_way), 32'(e_way));
    chk("R6", "rs_tag_miss", 32'(rs_tag_miss), 32'(e_tm));
    chk("R4", "rs_xlt_miss", 32'(rs_xlt_miss), 32'(e_xm));
    chk("R3", "rs_ppn", 32'(rs_ppn), 32'(e_ppn));
    if (rs_valid) chk("R7", "outcome count", 32'(rs_hit + rs_tag_miss + rs_xlt_miss), 32'd1);
  endtask

  // expected result of the presented lookup, from the model before this cycle's writes
  task automatic predict();
    bit x_hit = 0, t_hit = 0;
    logic [PW-1:0] pp = '0;
    logic [WW-1:0] wy = '0;
    for (int i = XE - 1; i >= 0; i--)
      if (m_xv[i] && m_xvpn[i] == lk_vpn && !(xl_wr_en && xl_wr_slot == SW'(i))) begin
        x_hit = 1; pp = m_xppn[i];
      end
    for (int w = NW - 1; w >= 0; w--)
      if (m_tv[lk_set][w] && m_tt[lk_set][w] == pp &&
          !(tg_wr_en && tg_wr_set == lk_set && tg_wr_way == WW'(w))) begin
        t_hit = 1; wy = WW'(w);
      end
    e_valid = lk_valid;
    e_xm    = lk_valid && !x_hit;
    e_hit   = lk_valid && x_hit && t_hit;
    e_tm    = lk_valid && x_hit && !t_hit;
    e_way   = e_hit ? wy : '0;
    e_ppn   = (lk_valid && x_hit) ? pp : '0;
  endtask

  task automatic apply_writes();
    if (tg_wr_en) begin
      m_tv[tg_wr_set][tg_wr_way] = tg_wr_valid;
      m_tt[tg_wr_set][tg_wr_way] = tg_wr_tag;
    end
    if (xl_wr_en) begin
      m_xv[xl_wr_slot]   = xl_wr_valid;
      m_xvpn[xl_wr_slot] = xl_wr_vpn;
      m_xppn[xl_wr_slot] = xl_wr_ppn;
    end
  endtask

  // called at a falling edge with inputs already set
  task automatic step();
    predict();
    apply_writes();
    @(negedge clk);
    check_result();
  endtask

  task automatic drive(input bit lv, input int ls, input int lvpn,
                       input bit tw, input int ts, input int twy, input bit tv, input int tt,
                       input bit xw, input int xs, input bit xv, input int xvpn, input int xppn);
    lk_valid = lv; lk_set = IW'(ls); lk_vpn = VW'(lvpn);
    tg_wr_en = tw; tg_wr_set = IW'(ts); tg_wr_way = WW'(twy);
    tg_wr_valid = tv; tg_wr_tag = PW'(tt);
    xl_wr_en = xw; xl_wr_slot = SW'(xs); xl_wr_valid = xv;
    xl_wr_vpn = VW'(xvpn); xl_wr_ppn = PW'(xppn);
    step();
  endtask

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < NW; w++) begin m_tv[s][w] = 0; m_tt[s][w] = '0; end
    for (int i = 0; i < XE; i++) begin m_xv[i] = 0; m_xvpn[i] = '0; m_xppn[i] = '0; end
    void'($urandom(32'h1d2c3b4a));

    repeat (3) @(negedge clk);
    // R1: quiet outputs during reset
    chk("R1", "rs_valid in reset", 32'(rs_valid), 0);
    chk("R1", "flags in reset", 32'({rs_hit, rs_tag_miss, rs_xlt_miss}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty tables give a translation miss
    drive(1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: fill slot 0 (vpn 3 -> ppn 5) and set 1 way 1 tag 5
    drive(0, 0, 0, 1, 1, 1, 1, 5, 1, 0, 1, 3, 5);
    // R5: hit in way 1, R3: page 5
    drive(1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6: other set, tag miss with page still given
    drive(1, 2, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: write to the hit way in the lookup cycle blocks it
    drive(1, 1, 3, 1, 1, 1, 1, 5, 0, 0, 0, 0, 0);
    // R9: write to the other way leaves way 1 matching
    drive(1, 1, 3, 1, 1, 0, 1, 5, 0, 0, 0, 0, 0);
    // R5: both ways now match, lowest wins
    drive(1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10: write to slot 0 in the lookup cycle blocks the translation
    drive(1, 1, 3, 0, 0, 0, 0, 0, 1, 0, 1, 3, 5);
    // R8: invalidate slot 0, then R4 translation miss dominates
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 3, 5);
    drive(1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R3: duplicate pages in slots 1 and 2, lowest slot wins
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 1, 4, 6);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 4, 2);
    drive(1, 0, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: idle cycle
    drive(0, 3, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      drive(($urandom % 10) < 8, $urandom % SETS, $urandom % 6,
            ($urandom % 10) < 3, $urandom % SETS, $urandom % NW,
            ($urandom % 20) < 17, ($urandom % 6) + 1,
            ($urandom % 10) < 2, $urandom % XE,
            ($urandom % 20) < 17, $urandom % 6, ($urandom % 6) + 1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule